// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the transmit and receive error counters of a CAN node and derives its error state from them. The protocol engine reports what happened on the bus as single-cycle event pulses: a completed reception, a stuff, CRC or form error seen while receiving, a bit error or a missing acknowledge while transmitting, and a completed transmission. The unit moves the counters, flags the node as error-passive, and switches it to bus-off once the transmit counter is full. While in bus-off the node may not send and the counters are frozen.

After every failed transmission the unit decides whether the frame is sent again. It asks for a retry unless single-shot mode is selected or the failure has just pushed the node into bus-off. Bus-off ends in one of two ways. With automatic restart enabled, the unit counts runs of recessive bits on the receive line and leaves bus-off on its own. Otherwise a software restart pulse brings the node back. Both exits clear the counters.

The unit also watches the receive line for a stuck-dominant condition. Every cause has its own status flag, and software clears a flag by writing 1 to it. All the flags drive one shared interrupt line.

Top module: `can_fault_conf`

## Requirements
- R1: A transmit failure (`ev_bit_err` or `ev_ack_miss`; both in one cycle count once) raises the transmit counter by 8, saturating at 255, at the clock edge that samples it. A failure takes precedence over `ev_tx_done` in the same cycle.
- R2: After a failed transmission that is not in single-shot mode and does not take the counter to 255, `tx_retry` is high for exactly the one cycle that follows the event. Retries therefore go on until an acknowledge arrives or the node enters bus-off.
- R3: With `single_shot` high, a failed transmission never raises `tx_retry`, even when the failure was a missing acknowledge.
- R4: When the transmit counter reaches 255, `bus_off` is set at the same edge, no retry is requested, and flag bit 6 is set. The receive counter never causes bus-off.
- R5: `ev_tx_done` lowers the transmit counter by 1 and `ev_rx_done` lowers the receive counter by 1. Neither counter goes below 0.
- R6: Any of `ev_stuff_err`, `ev_crc_err` or `ev_form_err` raises the receive counter by 1, counted once per cycle, saturating at 255. It takes precedence over `ev_rx_done` in the same cycle.
- R7: `err_passive` is high exactly when either counter is 128 or more.
- R8: While `bus_off` is high, event pulses do not change either counter.
- R9: With `auto_restart` high, the node leaves bus-off one cycle after the bit tick that completes the 128th run of 11 consecutive recessive bits (`rx_line`=1). A dominant bit tick restarts the run in progress. Both counters read 0 on exit.
- R10: With `auto_restart` low, the node stays in bus-off whatever the line does. A `sw_restart` pulse during bus-off leaves it at the next edge and clears both counters. A `sw_restart` pulse outside bus-off has no effect.
- R11: The 12th consecutive bit tick with `rx_line`=0 sets flag bit 7, once per dominant episode. A recessive bit tick ends the episode.
- R12: `int_flags` bits are 0 received message, 1 stuff, 2 CRC, 3 form, 4 bit, 5 acknowledge, 6 bus-off entry, 7 stuck dominant. Each bit is set by its event at the next edge. It is cleared by a `flag_clr_we` cycle whose `flag_clr_mask` bit is 1, and a set in the same cycle wins over the clear. `irq` is the OR of all flags, and everything is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time, sampling `rx_line` |
| rx_line | input | 1 | Receive line level, 0 = dominant |
| ev_rx_done | input | 1 | Frame received successfully |
| ev_stuff_err | input | 1 | Stuff error while receiving |
| ev_crc_err | input | 1 | CRC error while receiving |
| ev_form_err | input | 1 | Form error while receiving |
| ev_bit_err | input | 1 | Bit error while transmitting |
| ev_ack_miss | input | 1 | Transmitted frame got no acknowledge |
| ev_tx_done | input | 1 | Frame transmitted successfully |
| single_shot | input | 1 | Do not resend failed frames |
| auto_restart | input | 1 | Leave bus-off without software |
| sw_restart | input | 1 | Software restart pulse |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_mask | input | 8 | Write-1-to-clear mask for the flags |
| tx_err_cnt | output | 8 | Transmit error counter |
| rx_err_cnt | output | 8 | Receive error counter |
| err_passive | output | 1 | Error-passive state |
| bus_off | output | 1 | Bus-off state; transmission forbidden |
| tx_retry | output | 1 | Resend the failed frame |
| int_flags | output | 8 | Per-cause interrupt flags |
| irq | output | 1 | Shared interrupt |

## Verification
The hardest situation to reach from the ports is the automatic exit from bus-off. It needs a transmit counter driven all the way to 255 and then 1408 recessive bit ticks, with a dominant tick placed inside the last run so that an off-by-one in the run or run-count logic shows up as an early or late exit. Directed stimulus gets there with a burst of missing-acknowledge events followed by long tick trains. Random event traffic, biased towards transmit failures and broken by random software restarts, then passes through bus-off many times, and each cycle is compared with a reference model in the bench.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int NFLAG    = 8;
  localparam int FL_RXMSG = 0;
  localparam int FL_STUFF = 1;
  localparam int FL_CRC   = 2;
  localparam int FL_FORM  = 3;
  localparam int FL_BIT   = 4;
  localparam int FL_ACK   = 5;
  localparam int FL_BOFF  = 6;
  localparam int FL_STUCK = 7;

  // counter step up with saturation
  function automatic int sat_up(input int v, input int step, input int maxv);
    return (v + step > maxv) ? maxv : v + step;
  endfunction

  // counter step down, floored at zero
  function automatic int dec_floor(input int v);
    return (v > 0) ? v - 1 : 0;
  endfunction
endpackage

// File: rtl/fc_err_counters.sv
module fc_err_counters import can_fc_pkg::*; #(
  parameter int CNT_W     = 8,
  parameter int FAIL_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             freeze,
  input  logic             tx_fail,
  input  logic             tx_done,
  input  logic             rx_fail,
  input  logic             rx_done,
  output logic [CNT_W-1:0] tec_q,
  output logic [CNT_W-1:0] rec_q,
  output logic [CNT_W-1:0] tec_nxt
);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] rec_nxt;

  always_comb begin
    tec_nxt = tec_q;
    rec_nxt = rec_q;
    if (clr) begin
      tec_nxt = '0;
      rec_nxt = '0;
    end else if (!freeze) begin
      if (tx_fail)      tec_nxt = CNT_W'(sat_up(int'(tec_q), FAIL_STEP, CMAX));
      else if (tx_done) tec_nxt = CNT_W'(dec_floor(int'(tec_q)));
      if (rx_fail)      rec_nxt = CNT_W'(sat_up(int'(rec_q), 1, CMAX));
      else if (rx_done) rec_nxt = CNT_W'(dec_floor(int'(rec_q)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
    end else begin
      tec_q <= tec_nxt;
      rec_q <= rec_nxt;
    end
  end
endmodule

// File: rtl/fc_line_mon.sv
module fc_line_mon #(
  parameter int STUCK_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_line,
  output logic stuck_hit
);
  localparam int DW = $clog2(STUCK_LEN + 2);
  localparam logic [DW-1:0] HIT_AT = DW'(STUCK_LEN);
  localparam logic [DW-1:0] SAT_AT = DW'(STUCK_LEN + 1);

  logic [DW-1:0] dom_run;

  assign stuck_hit = bit_tick && !rx_line && (dom_run == HIT_AT);

  always_ff @(posedge clk) begin
    if (!rst_n)               dom_run <= '0;
    else if (bit_tick) begin
      if (rx_line)            dom_run <= '0;
      else if (dom_run != SAT_AT) dom_run <= dom_run + 1'b1;
    end
  end
endmodule

// File: rtl/fc_busoff.sv
module fc_busoff #(
  parameter int CNT_W     = 8,
  parameter int RUN_LEN   = 11,
  parameter int SEQ_COUNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic             auto_restart,
  input  logic             sw_restart,
  input  logic [CNT_W-1:0] tec_nxt,
  output logic             bus_off_q,
  output logic             enter_bo,
  output logic             leave_bo
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int SW = $clog2(SEQ_COUNT + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_LEN - 1);
  localparam logic [SW-1:0] SEQ_FULL = SW'(SEQ_COUNT);

  logic [RW-1:0] run_q;
  logic [SW-1:0] seq_q;
  logic          seq_full;

  assign seq_full = (seq_q == SEQ_FULL);
  assign enter_bo = !bus_off_q && (tec_nxt == '1);
  assign leave_bo = bus_off_q && (sw_restart || (auto_restart && seq_full));

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_off_q <= 1'b0;
    else if (enter_bo) bus_off_q <= 1'b1;
    else if (leave_bo) bus_off_q <= 1'b0;
  end

  // recessive run counting, only while in bus-off
  always_ff @(posedge clk) begin
    if (!rst_n || !bus_off_q || leave_bo) begin
      run_q <= '0;
      seq_q <= '0;
    end else if (bit_tick) begin
      if (!rx_line) run_q <= '0;
      else if (run_q == RUN_LAST) begin
        run_q <= '0;
        if (!seq_full) seq_q <= seq_q + 1'b1;
      end else run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/fc_irq_flags.sv
module fc_irq_flags #(
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flags_q,
  output logic          irq
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                      flags_q[i] <= 1'b0;
      else if (set_vec[i])             flags_q[i] <= 1'b1;
      else if (clr_we && clr_mask[i])  flags_q[i] <= 1'b0;
    end
  end

  assign irq = |flags_q;
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf import can_fc_pkg::*; #(
  parameter int CNT_W     = 8,
  parameter int FAIL_STEP = 8,
  parameter int RUN_LEN   = 11,
  parameter int SEQ_COUNT = 128,
  parameter int STUCK_LEN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic             ev_rx_done,
  input  logic             ev_stuff_err,
  input  logic             ev_crc_err,
  input  logic             ev_form_err,
  input  logic             ev_bit_err,
  input  logic             ev_ack_miss,
  input  logic             ev_tx_done,
  input  logic             single_shot,
  input  logic             auto_restart,
  input  logic             sw_restart,
  input  logic             flag_clr_we,
  input  logic [NFLAG-1:0] flag_clr_mask,
  output logic [CNT_W-1:0] tx_err_cnt,
  output logic [CNT_W-1:0] rx_err_cnt,
  output logic             err_passive,
  output logic             bus_off,
  output logic             tx_retry,
  output logic [NFLAG-1:0] int_flags,
  output logic             irq
);
  localparam logic [CNT_W-1:0] PASSIVE_AT = CNT_W'(1 << (CNT_W - 1));

  // named internal events
  logic             tx_fail, rx_fail;
  logic [CNT_W-1:0] tec_nxt;
  logic             enter_bo, leave_bo, stuck_hit;
  logic [NFLAG-1:0] flag_set;

  assign tx_fail = ev_bit_err | ev_ack_miss;
  assign rx_fail = ev_stuff_err | ev_crc_err | ev_form_err;

  fc_err_counters #(.CNT_W(CNT_W), .FAIL_STEP(FAIL_STEP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(leave_bo), .freeze(bus_off),
    .tx_fail(tx_fail), .tx_done(ev_tx_done), .rx_fail(rx_fail), .rx_done(ev_rx_done),
    .tec_q(tx_err_cnt), .rec_q(rx_err_cnt), .tec_nxt(tec_nxt)
  );

  fc_busoff #(.CNT_W(CNT_W), .RUN_LEN(RUN_LEN), .SEQ_COUNT(SEQ_COUNT)) u_bo (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
    .auto_restart(auto_restart), .sw_restart(sw_restart), .tec_nxt(tec_nxt),
    .bus_off_q(bus_off), .enter_bo(enter_bo), .leave_bo(leave_bo)
  );

  fc_line_mon #(.STUCK_LEN(STUCK_LEN)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line), .stuck_hit(stuck_hit)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FL_RXMSG] = ev_rx_done;
    flag_set[FL_STUFF] = ev_stuff_err;
    flag_set[FL_CRC]   = ev_crc_err;
    flag_set[FL_FORM]  = ev_form_err;
    flag_set[FL_BIT]   = ev_bit_err;
    flag_set[FL_ACK]   = ev_ack_miss;
    flag_set[FL_BOFF]  = enter_bo;
    flag_set[FL_STUCK] = stuck_hit;
  end

  fc_irq_flags #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(flag_set), .clr_we(flag_clr_we),
    .clr_mask(flag_clr_mask), .flags_q(int_flags), .irq(irq)
  );

  // retry decision, one cycle after the failure
  always_ff @(posedge clk) begin
    if (!rst_n) tx_retry <= 1'b0;
    else        tx_retry <= tx_fail && !single_shot && !bus_off && (tec_nxt != '1);
  end

  assign err_passive = (tx_err_cnt >= PASSIVE_AT) || (rx_err_cnt >= PASSIVE_AT);
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int CNT_W     = 8,
  parameter int FAIL_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_fail,
  input logic             ev_tx_done,
  input logic             single_shot,
  input logic             leave_bo,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             bus_off,
  input logic             tx_retry
);
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(FAIL_STEP);
  localparam logic [CNT_W-1:0] SAFE_V = CNT_W'(CMAX - FAIL_STEP);

  a_r1_fail_adds_step: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail && !bus_off && (tec < SAFE_V) |=> tec == $past(tec) + STEP_V);

  a_r2_retry_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail && !single_shot && !bus_off && (tec < SAFE_V) |=> tx_retry);

  a_r3_single_shot: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail && single_shot |=> !tx_retry);

  a_r4_no_retry_busoff: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> !tx_retry);

  a_r5_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tec == '0) && ev_tx_done && !tx_fail && !bus_off |=> tec == '0);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off && !leave_bo |=> $stable(tec) && $stable(rec));

  a_r10_exit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> (tec == '0) && (rec == '0));
endmodule

bind can_fault_conf can_fault_conf_chk #(.CNT_W(CNT_W), .FAIL_STEP(FAIL_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_fail(tx_fail), .ev_tx_done(ev_tx_done),
  .single_shot(single_shot), .leave_bo(leave_bo), .tec(tx_err_cnt), .rec(rx_err_cnt),
  .bus_off(bus_off), .tx_retry(tx_retry)
);

// File: tb/can_fault_conf_test.sv
module can_fault_conf_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bit_tick, rx_line;
  logic       ev_rx_done, ev_stuff_err, ev_crc_err, ev_form_err;
  logic       ev_bit_err, ev_ack_miss, ev_tx_done;
  logic       single_shot, auto_restart, sw_restart, flag_clr_we;
  logic [7:0] flag_clr_mask, tx_err_cnt, rx_err_cnt, int_flags;
  logic       err_passive, bus_off, tx_retry, irq;

  can_fault_conf uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  int m_tec, m_rec, m_flags;
  bit m_bo, m_retry;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ev_rx_done = 0; ev_stuff_err = 0; ev_crc_err = 0; ev_form_err = 0;
    ev_bit_err = 0; ev_ack_miss = 0; ev_tx_done = 0;
    sw_restart = 0; flag_clr_we = 0; bit_tick = 0; rx_line = 1;
  endtask

  task automatic tick_bits(int n, logic v);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; rx_line = v; step();
    end
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic clr_flags(logic [7:0] m);
    flag_clr_we = 1; flag_clr_mask = m; step();
  endtask

  // reference model for the random phase (no bit ticks there)
  function automatic int up(int v, int s);
    return (v + s > 255) ? 255 : v + s;
  endfunction
  function automatic int dn(int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_step();
    bit fail = ev_bit_err | ev_ack_miss;
    bit rxe = ev_stuff_err | ev_crc_err | ev_form_err;
    bit enter = 0;
    int set;
    if (m_bo && sw_restart) begin
      m_tec = 0; m_rec = 0; m_bo = 0; m_retry = 0;
    end else if (!m_bo) begin
      m_tec = fail ? up(m_tec, 8) : (ev_tx_done ? dn(m_tec) : m_tec);
      m_rec = rxe ? up(m_rec, 1) : (ev_rx_done ? dn(m_rec) : m_rec);
      enter = (m_tec == 255);
      m_bo = enter;
      m_retry = fail && !single_shot && !enter;
    end else m_retry = 0;
    set = {enter, ev_ack_miss, ev_bit_err, ev_form_err, ev_crc_err, ev_stuff_err, ev_rx_done};
    m_flags = set | (m_flags & ~(flag_clr_we ? int'(flag_clr_mask) : 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit_tick = 0; rx_line = 1; single_shot = 0; auto_restart = 0; flag_clr_mask = 0;
    step();
    do_reset();
    chk("R12 reset flags", int_flags, 0);
    chk("R12 reset irq", irq, 0);
    chk("R1 reset tec", tx_err_cnt, 0);
    chk("R7 reset passive", err_passive, 0);
    chk("R4 reset bus_off", bus_off, 0);

    ev_ack_miss = 1; step();
    chk("R1 ack miss +8", tx_err_cnt, 8);
    chk("R2 retry after ack miss", tx_retry, 1);
    chk("R12 ack flag", int_flags, 8'h20);
    step();
    chk("R2 retry one cycle", tx_retry, 0);
    ev_bit_err = 1; ev_ack_miss = 1; ev_tx_done = 1; step();
    chk("R1 double failure once", tx_err_cnt, 16);
    single_shot = 1; ev_ack_miss = 1; step();
    chk("R3 single shot tec", tx_err_cnt, 24);
    chk("R3 single shot no retry", tx_retry, 0);
    single_shot = 0;
    repeat (3) begin ev_tx_done = 1; step(); end
    chk("R5 tx done decrements", tx_err_cnt, 21);
    ev_rx_done = 1; step();
    chk("R5 rec floor", rx_err_cnt, 0);
    ev_stuff_err = 1; ev_crc_err = 1; step();
    chk("R6 rx errors once", rx_err_cnt, 1);
    ev_form_err = 1; ev_rx_done = 1; step();
    chk("R6 error beats rx done", rx_err_cnt, 2);
    ev_rx_done = 1; step();
    chk("R5 rx done decrements", rx_err_cnt, 1);

    chk("R12 flags accumulate", int_flags, 8'h3F);
    clr_flags(8'h0F);
    chk("R12 w1c mask", int_flags, 8'h30);
    flag_clr_we = 1; flag_clr_mask = 8'h20; ev_ack_miss = 1; step();
    chk("R12 set wins over clear", int_flags, 8'h30);
    clr_flags(8'hFF);
    chk("R12 cleared", int_flags, 0);
    chk("R12 irq low", irq, 0);

    repeat (126) begin ev_crc_err = 1; step(); end
    chk("R7 rec 127", rx_err_cnt, 127);
    chk("R7 not passive at 127", err_passive, 0);
    ev_form_err = 1; step();
    chk("R7 passive at 128", err_passive, 1);
    ev_rx_done = 1; step();
    chk("R7 back active", err_passive, 0);
    repeat (130) begin ev_stuff_err = 1; step(); end
    chk("R6 rec saturates", rx_err_cnt, 255);
    chk("R4 rec does not bus off", bus_off, 0);

    repeat (28) begin ev_ack_miss = 1; step(); end
    chk("R1 tec 253", tx_err_cnt, 253);
    chk("R2 retry before bus off", tx_retry, 1);
    chk("R4 still active", bus_off, 0);
    ev_ack_miss = 1; step();
    chk("R1 tec saturates", tx_err_cnt, 255);
    chk("R4 bus off entered", bus_off, 1);
    chk("R4 no retry on entry", tx_retry, 0);
    chk("R4 bus off flag", int_flags[6], 1);

    ev_tx_done = 1; step();
    ev_rx_done = 1; step();
    ev_ack_miss = 1; ev_stuff_err = 1; step();
    chk("R8 tec frozen", tx_err_cnt, 255);
    chk("R8 rec frozen", rx_err_cnt, 255);

    tick_bits(1430, 1'b1); step();
    chk("R10 stays without auto", bus_off, 1);
    sw_restart = 1; step();
    chk("R10 sw restart exits", bus_off, 0);
    chk("R10 tec cleared", tx_err_cnt, 0);
    chk("R10 rec cleared", rx_err_cnt, 0);
    ev_ack_miss = 1; step();
    sw_restart = 1; step();
    chk("R10 restart ignored when active", tx_err_cnt, 8);

    for (int i = 0; i < 40 && !bus_off; i++) begin ev_ack_miss = 1; step(); end
    chk("R9 bus off again", bus_off, 1);
    auto_restart = 1;
    tick_bits(127 * 11 + 5, 1'b1);
    tick_bits(1, 1'b0);
    tick_bits(10, 1'b1);
    step(); step();
    chk("R9 dominant restarts run", bus_off, 1);
    tick_bits(1, 1'b1);
    step();
    chk("R9 auto exit", bus_off, 0);
    chk("R9 tec cleared", tx_err_cnt, 0);
    chk("R9 rec cleared", rx_err_cnt, 0);
    auto_restart = 0;

    clr_flags(8'hFF);
    tick_bits(11, 1'b0);
    chk("R11 eleven dominant quiet", int_flags[7], 0);
    tick_bits(1, 1'b0);
    chk("R11 twelfth dominant", int_flags[7], 1);
    chk("R11 irq", irq, 1);
    clr_flags(8'h80);
    tick_bits(5, 1'b0);
    chk("R11 once per episode", int_flags[7], 0);
    tick_bits(1, 1'b1);
    tick_bits(11, 1'b0);
    chk("R11 recessive restarts", int_flags[7], 0);
    tick_bits(1, 1'b0);
    chk("R11 second episode", int_flags[7], 1);

    // constrained random phase against the model
    void'($urandom(32'd20240611));
    do_reset();
    m_tec = 0; m_rec = 0; m_bo = 0; m_retry = 0; m_flags = 0;
    for (int c = 0; c < 3000; c++) begin
      ev_ack_miss  = ($urandom % 8) == 0;
      ev_bit_err   = ($urandom % 16) == 0;
      ev_tx_done   = ($urandom % 3) == 0;
      ev_stuff_err = ($urandom % 10) == 0;
      ev_crc_err   = ($urandom % 12) == 0;
      ev_form_err  = ($urandom % 14) == 0;
      ev_rx_done   = ($urandom % 4) == 0;
      single_shot  = ($urandom % 5) == 0;
      sw_restart   = ($urandom % 40) == 0;
      flag_clr_we  = ($urandom % 4) == 0;
      flag_clr_mask = 8'($urandom);
      model_step();
      step();
      chk("R1 R5 random tec", tx_err_cnt, m_tec);
      chk("R6 random rec", rx_err_cnt, m_rec);
      chk("R4 R10 random bus off", bus_off, m_bo);
      chk("R2 R3 random retry", tx_retry, m_retry);
      chk("R12 random flags", int_flags, m_flags);
      chk("R12 random irq", irq, m_flags != 0);
      chk("R7 random passive", err_passive, (m_tec >= 128) || (m_rec >= 128));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule